// File: doc/BRIEF.md
# Cascadable multiply-add slice

This block is a pipelined signed multiplier followed by a three-operand 48-bit adder and logic unit. A 25-bit and an 18-bit two's-complement operand are multiplied. The product, the slice's own previous result, an independent 48-bit C word, or a 48-bit word from the neighbouring slice are routed into the adder by a 7-bit operand-select word. A 4-bit function word picks addition, subtraction or a bitwise operation. The result is registered, and that register also drives a cascade output, so a row of slices can form a long adder chain with no extra logic between them. The B operand is forwarded on a second cascade output so the next slice can reuse it.

Each data path has its own clock enable. A comparator checks the result against a constant pattern under a mask. Its flag is registered with the result, which is the hook used for convergent rounding. Register depth on each path is set by a parameter. With the defaults (one A stage, one B stage, one product stage, one result stage), the result appears three cycles after A and B are presented.

Top module: `cascade_mac_slice`

## Requirements
- R1: While `rst_ni` is low, every pipeline register is cleared at once, without waiting for a clock edge. `p_o`, `casc_o`, `b_casc_o`, `carry_o` and `match_o` read 0.
- R2: With select word 7'b000_01_01 (Z zero, Y product, X product) and function 4'b0000, `p_o` equals the 48-bit sign extension of a_i*b_i. The operands are treated as signed. The default pipeline delivers it three clock edges after A and B are presented.
- R3: The select word, the function word, `c_i`, `casc_i` and `carry_i` are sampled only at the result stage, so they take effect on the next clock edge.
- R4: Z is selected by bits [6:4]: 000 gives zero, 001 gives `casc_i`, 010 gives the current result (accumulate), and 011 gives `c_i`.
- R5: X is selected by bits [1:0]: 00 gives zero, 01 gives the product, 10 gives the current result. Y is selected by bits [3:2]: 00 gives zero, 01 pairs with X=01 for the product, 10 gives all ones.
- R6: The result and carry are forced to 0 in any of these cases: X=11, Y=11, exactly one of X and Y equal to 01, Z bit 6 set, or a function word outside {0000, 0011, 0100, 1100, 1110}.
- R7: Function 4'b0011 gives Z - (X + Y + carry_i). Function 4'b0000 gives Z + X + Y + carry_i.
- R8: Functions 4'b0100, 4'b1100 and 4'b1110 give X xor Z, X and Z, and X or Z. Y and `carry_i` are ignored, and `carry_o` is 0.
- R9: `carry_o` is bit 48 of the sum or difference, computed on operands zero-extended to 50 bits.
- R10: `match_o` is 1 exactly when (result xor PATTERN) and not MASK is zero. A MASK bit of 1 ignores that bit. The flag is registered together with `p_o`.
- R11: `casc_o` always equals `p_o`. `b_casc_o` carries B after its input stage, one edge after `b_i`.
- R12: When an enable is low, its stage holds: `ce_a_i` for A, `ce_b_i` for B, `ce_m_i` for the product, and `ce_p_i` for the result, carry and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 25 | Signed multiplier operand A |
| b_i | input | 18 | Signed multiplier operand B |
| c_i | input | 48 | Independent adder operand |
| casc_i | input | 48 | Result word from the previous slice |
| carry_i | input | 1 | Adder carry-in |
| opmode_i | input | 7 | Operand select {Z[2:0], Y[1:0], X[1:0]} |
| alumode_i | input | 4 | Adder/logic function |
| ce_a_i | input | 1 | Enable for A stages |
| ce_b_i | input | 1 | Enable for B stages |
| ce_m_i | input | 1 | Enable for product stage |
| ce_p_i | input | 1 | Enable for result stage |
| p_o | output | 48 | Result |
| casc_o | output | 48 | Result to next slice |
| b_casc_o | output | 18 | Staged B to next slice |
| carry_o | output | 1 | Carry-out, bit 48 |
| match_o | output | 1 | Masked pattern match on the result |

## Verification
A wrong value held in the product stage reaches `p_o` one edge later, and only under select words that route the product. A corrupt result register is more visible: it shows at once on `p_o` and `casc_o`, and through accumulate or X=P it keeps growing in later cycles. A reference model advanced on every edge, including the edges where the enables are low, exposes a mis-staged path within one or two cycles. The same holds for an enable wired to the wrong stage, since the product and result then drift out of step with the inputs.

// File: rtl/slice_pkg.sv
package slice_pkg;
  typedef enum logic [3:0] {
    ALU_ADD = 4'b0000,
    ALU_SUB = 4'b0011,
    ALU_XOR = 4'b0100,
    ALU_AND = 4'b1100,
    ALU_OR  = 4'b1110
  } alu_fn_e;

  typedef enum logic [1:0] {XS_ZERO = 2'd0, XS_PROD = 2'd1, XS_PREV = 2'd2, XS_BAD = 2'd3} x_sel_e;
  typedef enum logic [1:0] {YS_ZERO = 2'd0, YS_PROD = 2'd1, YS_ONES = 2'd2, YS_BAD = 2'd3} y_sel_e;
  typedef enum logic [2:0] {ZS_ZERO = 3'd0, ZS_CASC = 3'd1, ZS_PREV = 3'd2, ZS_C = 3'd3} z_sel_e;
endpackage

// File: rtl/slice_pipe.sv
module slice_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (DEPTH == 0) begin : g_thru
      logic unused_ctl;
      assign unused_ctl = clk_i ^ rst_ni ^ en_i;
      assign q_o = d_i;
    end else begin : g_regs
      logic [W-1:0] st_q [DEPTH];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < DEPTH; i++) st_q[i] <= '0;
        end else if (en_i) begin
          st_q[0] <= d_i;
          for (int i = 1; i < DEPTH; i++) st_q[i] <= st_q[i-1];
        end
      end
      assign q_o = st_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/slice_opmux.sv
module slice_opmux
  import slice_pkg::*;
#(
  parameter int P_W = 48
) (
  input  logic [6:0]     opmode_i,
  input  logic [P_W-1:0] prod_i,
  input  logic [P_W-1:0] fb_i,
  input  logic [P_W-1:0] c_i,
  input  logic [P_W-1:0] casc_i,
  output logic [P_W-1:0] x_o,
  output logic [P_W-1:0] y_o,
  output logic [P_W-1:0] z_o,
  output logic           legal_o
);
  x_sel_e xs;
  y_sel_e ys;
  logic   z_ok;

  assign xs = x_sel_e'(opmode_i[1:0]);
  assign ys = y_sel_e'(opmode_i[3:2]);

  always_comb begin
    unique case (xs)
      XS_PROD: x_o = prod_i;
      XS_PREV: x_o = fb_i;
      default: x_o = '0;
    endcase
    // product arrives whole on X; the Y half of the pair adds nothing
    unique case (ys)
      YS_ONES: y_o = '1;
      default: y_o = '0;
    endcase
    z_ok = 1'b1;
    case (opmode_i[6:4])
      ZS_ZERO: z_o = '0;
      ZS_CASC: z_o = casc_i;
      ZS_PREV: z_o = fb_i;
      ZS_C:    z_o = c_i;
      default: begin z_o = '0; z_ok = 1'b0; end
    endcase
  end

  assign legal_o = z_ok && (xs != XS_BAD) && (ys != YS_BAD)
                   && ((xs == XS_PROD) == (ys == YS_PROD));
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_pkg::*;
#(
  parameter int P_W = 48
) (
  input  logic [P_W-1:0] x_i,
  input  logic [P_W-1:0] y_i,
  input  logic [P_W-1:0] z_i,
  input  logic           cin_i,
  input  logic [3:0]     alumode_i,
  input  logic           legal_i,
  output logic [P_W-1:0] res_o,
  output logic           cout_o
);
  localparam int EW = P_W + 2;

  logic [EW-1:0] xe, ye, ze, ce, sum;
  logic          fn_ok;

  assign xe = {2'b00, x_i};
  assign ye = {2'b00, y_i};
  assign ze = {2'b00, z_i};
  assign ce = {{(EW-1){1'b0}}, cin_i};

  always_comb begin
    fn_ok = 1'b1;
    case (alumode_i)
      ALU_ADD: sum = ze + xe + ye + ce;
      ALU_SUB: sum = ze - (xe + ye + ce);
      ALU_XOR: sum = xe ^ ze;
      ALU_AND: sum = xe & ze;
      ALU_OR:  sum = xe | ze;
      default: begin sum = '0; fn_ok = 1'b0; end
    endcase
  end

  assign res_o  = (legal_i && fn_ok) ? sum[P_W-1:0] : '0;
  assign cout_o = legal_i && fn_ok && sum[P_W];
endmodule

// File: rtl/cascade_mac_slice.sv
module cascade_mac_slice
  import slice_pkg::*;
#(
  parameter int A_W  = 25,
  parameter int B_W  = 18,
  parameter int P_W  = 48,
  parameter int AREG = 1,
  parameter int BREG = 1,
  parameter int MREG = 1,
  parameter int PREG = 1,
  parameter logic [P_W-1:0] PATTERN = '0,
  parameter logic [P_W-1:0] MASK    = {{(P_W-8){1'b0}}, 8'hFF}
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic [P_W-1:0] c_i,
  input  logic [P_W-1:0] casc_i,
  input  logic           carry_i,
  input  logic [6:0]     opmode_i,
  input  logic [3:0]     alumode_i,
  input  logic           ce_a_i,
  input  logic           ce_b_i,
  input  logic           ce_m_i,
  input  logic           ce_p_i,
  output logic [P_W-1:0] p_o,
  output logic [P_W-1:0] casc_o,
  output logic [B_W-1:0] b_casc_o,
  output logic           carry_o,
  output logic           match_o
);
  localparam int PROD_W = A_W + B_W;
  localparam int OUT_W  = P_W + 2;

  logic [A_W-1:0]           a_d;
  logic [B_W-1:0]           b_d;
  logic signed [PROD_W-1:0] prod_full;
  logic [P_W-1:0]           prod_ext, m_d, fb;
  logic [P_W-1:0]           x_v, y_v, z_v, res;
  logic                     legal, cout, hit;
  logic [OUT_W-1:0]         out_d, out_q;

  slice_pipe #(.W(A_W), .DEPTH(AREG)) u_a_pipe (
    .clk_i, .rst_ni, .en_i(ce_a_i), .d_i(a_i), .q_o(a_d));
  slice_pipe #(.W(B_W), .DEPTH(BREG)) u_b_pipe (
    .clk_i, .rst_ni, .en_i(ce_b_i), .d_i(b_i), .q_o(b_d));

  assign prod_full = $signed(a_d) * $signed(b_d);
  assign prod_ext  = {{(P_W-PROD_W){prod_full[PROD_W-1]}}, prod_full};

  slice_pipe #(.W(P_W), .DEPTH(MREG)) u_m_pipe (
    .clk_i, .rst_ni, .en_i(ce_m_i), .d_i(prod_ext), .q_o(m_d));

  // without an output register there is nothing to feed back
  generate
    if (PREG != 0) begin : g_fb
      assign fb = p_o;
    end else begin : g_nofb
      assign fb = '0;
    end
  endgenerate

  slice_opmux #(.P_W(P_W)) u_opmux (
    .opmode_i, .prod_i(m_d), .fb_i(fb), .c_i, .casc_i,
    .x_o(x_v), .y_o(y_v), .z_o(z_v), .legal_o(legal));

  slice_alu #(.P_W(P_W)) u_alu (
    .x_i(x_v), .y_i(y_v), .z_i(z_v), .cin_i(carry_i), .alumode_i,
    .legal_i(legal), .res_o(res), .cout_o(cout));

  assign hit   = ((res ^ PATTERN) & ~MASK) == '0;
  assign out_d = {hit, cout, res};

  slice_pipe #(.W(OUT_W), .DEPTH(PREG)) u_p_pipe (
    .clk_i, .rst_ni, .en_i(ce_p_i), .d_i(out_d), .q_o(out_q));

  assign p_o      = out_q[P_W-1:0];
  assign carry_o  = out_q[P_W];
  assign match_o  = out_q[P_W+1];
  assign casc_o   = p_o;
  assign b_casc_o = b_d;
endmodule

// File: rtl/slice_checker.sv
module slice_checker #(
  parameter int P_W  = 48,
  parameter int B_W  = 18,
  parameter int BREG = 1,
  parameter int PREG = 1,
  parameter logic [P_W-1:0] PATTERN = '0,
  parameter logic [P_W-1:0] MASK    = '0
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           ce_b_i,
  input logic           ce_p_i,
  input logic [B_W-1:0] b_i,
  input logic [6:0]     opmode_i,
  input logic [3:0]     alumode_i,
  input logic           carry_i,
  input logic [P_W-1:0] p_o,
  input logic           carry_o,
  input logic           match_o,
  input logic [B_W-1:0] b_casc_o
);
  generate
    if (PREG == 1) begin : g_p
      a_r12_p_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ce_p_i |=> ($stable(p_o) && $stable(carry_o) && $stable(match_o)));

      a_r6_illegal_z: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_p_i && opmode_i[6]) |=> (p_o == '0 && !carry_o));

      a_r8_logic_no_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_p_i && (alumode_i inside {4'b0100, 4'b1100, 4'b1110})) |=> !carry_o);

      a_r10_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ce_p_i |=> (match_o == (((p_o ^ PATTERN) & ~MASK) == '0)));

      a_r4_accum_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_p_i && opmode_i == 7'b010_00_00 && alumode_i == 4'b0000 && !carry_i)
        |=> $stable(p_o));
    end
    if (BREG == 1) begin : g_b
      a_r11_b_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ce_b_i |=> (b_casc_o == $past(b_i)));
    end
  endgenerate
endmodule

bind cascade_mac_slice slice_checker #(
  .P_W(P_W), .B_W(B_W), .BREG(BREG), .PREG(PREG), .PATTERN(PATTERN), .MASK(MASK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_b_i(ce_b_i), .ce_p_i(ce_p_i), .b_i(b_i),
  .opmode_i(opmode_i), .alumode_i(alumode_i), .carry_i(carry_i), .p_o(p_o),
  .carry_o(carry_o), .match_o(match_o), .b_casc_o(b_casc_o)
);

// File: tb/cascade_mac_slice_bench.sv
`timescale 1ns/1ps
module cascade_mac_slice_bench;
  localparam logic [47:0] PAT  = 48'h0;
  localparam logic [47:0] MSK  = 48'h0000_0000_00FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [24:0] a = '0;
  logic [17:0] b = '0;
  logic [47:0] c = '0, casc = '0;
  logic        cin = 1'b0;
  logic [6:0]  opmode = '0;
  logic [3:0]  alumode = '0;
  logic        ce_a = 1'b1, ce_b = 1'b1, ce_m = 1'b1, ce_p = 1'b1;
  logic [47:0] p_o, casc_o;
  logic [17:0] b_casc_o;
  logic        carry_o, match_o;

  int    total = 0, bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1 reset";

  always #10 clk = ~clk;

  cascade_mac_slice u_cascade_mac_slice (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .c_i(c), .casc_i(casc),
    .carry_i(cin), .opmode_i(opmode), .alumode_i(alumode),
    .ce_a_i(ce_a), .ce_b_i(ce_b), .ce_m_i(ce_m), .ce_p_i(ce_p),
    .p_o(p_o), .casc_o(casc_o), .b_casc_o(b_casc_o), .carry_o(carry_o), .match_o(match_o));

  // behavioural reference state
  logic [24:0] ma;
  logic [17:0] mb;
  logic [47:0] mm, mp;
  logic        mc, mt;

  function automatic logic [48:0] ref_calc(logic [47:0] m, logic [47:0] pv, logic [47:0] cv,
                                           logic [47:0] kv, logic [6:0] op, logic [3:0] al,
                                           logic ci);
    logic [1:0]  xs, ys;
    logic [49:0] x, y, z, s;
    logic        ok;
    xs = op[1:0];
    ys = op[3:2];
    ok = (op[6:4] <= 3'd3) && (xs != 2'd3) && (ys != 2'd3) && ((xs == 2'd1) == (ys == 2'd1));
    x = (xs == 2'd1) ? {2'b00, m} : (xs == 2'd2) ? {2'b00, pv} : 50'd0;
    y = (ys == 2'd2) ? {2'b00, {48{1'b1}}} : 50'd0;
    case (op[6:4])
      3'd1:    z = {2'b00, kv};
      3'd2:    z = {2'b00, pv};
      3'd3:    z = {2'b00, cv};
      default: z = 50'd0;
    endcase
    case (al)
      4'b0000: s = z + x + y + {49'd0, ci};
      4'b0011: s = z - (x + y + {49'd0, ci});
      4'b0100: s = x ^ z;
      4'b1100: s = x & z;
      4'b1110: s = x | z;
      default: begin s = 50'd0; ok = 1'b0; end
    endcase
    return ok ? {s[48], s[47:0]} : 49'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma = '0; mb = '0; mm = '0; mp = '0; mc = 1'b0; mt = 1'b0;
    end else begin
      logic [48:0]        r;
      logic signed [42:0] pr;
      if (ce_p) begin
        r  = ref_calc(mm, mp, c, casc, opmode, alumode, cin);
        mp = r[47:0];
        mc = r[48];
        mt = ((mp ^ PAT) & ~MSK) == 48'd0;
      end
      if (ce_m) begin
        pr = $signed(ma) * $signed(mb);
        mm = {{5{pr[42]}}, pr};
      end
      if (ce_a) ma = a;
      if (ce_b) mb = b;
    end
  end

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R1 p_o in reset", p_o, 48'd0);
        chk("R1 casc_o in reset", casc_o, 48'd0);
        chk("R1 b_casc_o in reset", {30'd0, b_casc_o}, 48'd0);
        chk("R1 flags in reset", {46'd0, carry_o, match_o}, 48'd0);
      end else begin
        chk(cur_req, p_o, mp);
        chk("R11 casc_o", casc_o, mp);
        chk("R11 b_casc_o", {30'd0, b_casc_o}, {30'd0, mb});
        chk("R9 carry_o", {47'd0, carry_o}, {47'd0, mc});
        chk("R10 match_o", {47'd0, match_o}, {47'd0, mt});
      end
    end
  end

  // mode: 0 random, 1 small operands, 2 C all ones, 3 keep A/B
  task automatic run(input string tag, input logic [6:0] op, input logic [3:0] al,
                     input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      cur_req = tag;
      opmode  = op;
      alumode = al;
      if (mode == 1) begin
        a = 25'($urandom_range(0, 15));
        b = 18'($urandom_range(0, 15));
      end else if (mode != 3) begin
        a = 25'($urandom);
        b = 18'($urandom);
      end
      c    = (mode == 2) ? 48'hFFFF_FFFF_FFFF : ((mode == 1) ? 48'd0 : 48'({$urandom, $urandom}));
      casc = 48'({$urandom, $urandom});
      cin  = (mode == 1) ? 1'b0 : 1'($urandom);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog R1-run actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    run("R2 product", 7'b000_01_01, 4'b0000, 20, 0);
    @(posedge clk); #2 a = 25'h100_0000; b = 18'h2_0000;
    run("R2 most negative operands", 7'b000_01_01, 4'b0000, 4, 3);
    @(posedge clk); #2 a = 25'h1FF_FFFF; b = 18'h1_FFFF;
    run("R2 minus one times max", 7'b000_01_01, 4'b0000, 4, 3);
    run("R4 Z=C", 7'b011_01_01, 4'b0000, 10, 0);
    run("R4 Z=cascade", 7'b001_01_01, 4'b0000, 10, 0);
    run("R4 Z=P accumulate", 7'b010_01_01, 4'b0000, 12, 0);
    run("R4 hold with zero operands", 7'b010_00_00, 4'b0000, 3, 1);
    run("R5 Y all ones", 7'b000_10_00, 4'b0000, 6, 0);
    run("R5 X=P plus Z=P", 7'b010_00_10, 4'b0000, 6, 0);
    run("R5 C plus ones", 7'b011_10_00, 4'b0000, 6, 0);
    for (int k = 0; k < 12; k++) begin
      run("R3 per-cycle control", k[0] ? 7'b011_01_01 : 7'b001_10_00,
          k[1] ? 4'b0011 : 4'b0000, 1, 0);
    end
    run("R7 subtract", 7'b011_01_01, 4'b0011, 10, 0);
    run("R7 subtract ones", 7'b001_10_00, 4'b0011, 6, 0);
    run("R8 xor", 7'b011_01_01, 4'b0100, 6, 0);
    run("R8 and", 7'b011_01_01, 4'b1100, 6, 0);
    run("R8 or", 7'b001_10_10, 4'b1110, 6, 0);
    run("R6 X=11", 7'b011_00_11, 4'b0000, 3, 0);
    run("R6 Y=11", 7'b011_11_00, 4'b0000, 3, 0);
    run("R6 lone X product", 7'b011_00_01, 4'b0000, 3, 0);
    run("R6 lone Y product", 7'b011_01_00, 4'b0000, 3, 0);
    run("R6 Z bit6", 7'b100_01_01, 4'b0000, 3, 0);
    run("R6 bad function", 7'b011_01_01, 4'b0001, 3, 0);
    run("R9 carry add", 7'b011_01_01, 4'b0000, 10, 2);
    run("R9 carry subtract", 7'b000_01_01, 4'b0011, 10, 0);
    run("R10 match small", 7'b000_01_01, 4'b0000, 15, 1);
    for (int k = 0; k < 30; k++) begin
      @(posedge clk); #2;
      ce_a = 1'($urandom); ce_b = 1'($urandom);
      ce_m = 1'($urandom); ce_p = 1'($urandom);
      run("R12 enables", k[2] ? 7'b010_01_01 : 7'b011_01_01, 4'b0000, 1, 0);
    end
    @(posedge clk); #2 ce_a = 1'b1; ce_b = 1'b1; ce_m = 1'b1; ce_p = 1'b1;
    run("R2 after enables", 7'b000_01_01, 4'b0000, 5, 0);
    @(posedge clk); #2 rst_n = 1'b0;
    #3;
    chk("R1 async p_o", p_o, 48'd0);
    chk("R1 async b_casc_o", {30'd0, b_casc_o}, 48'd0);
    chk("R1 async flags", {46'd0, carry_o, match_o}, 48'd0);
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    run("R2 after reset", 7'b000_01_01, 4'b0000, 6, 0);
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule